// File: doc/BRIEF.md
# Shadowed Video Timing Generator

This block produces the raster timing for a display path from a single pixel clock. It drives active-high horizontal sync, vertical sync and data-enable, and reports the column and row of the current pixel inside the visible area. Each line runs through four regions: sync, back porch, active and front porch. A frame runs through the same four regions counted in whole lines. The line length and the frame length are the sums of their four fields.

A host programs the timing through a one-cycle write port. Writes land in a shadow set of registers and do not touch the raster that is running. To apply them, the host writes the update word. The shadow set then moves into the active set on the last pixel clock of the current frame, so the next frame starts with the new timing. The request clears itself once the copy is done. A control word holds a delay, in pixel clocks, that moves both edges of vertical sync later relative to the line start.

Top module: `vid_timing_gen`

## Requirements
- R1: While reset is asserted both counters sit at pixel 0 of line 0, the start of the sync region. With the reset delay of 0, hsync and vsync are then high, de is low, and pos_x and pos_y are 0.
- R2: Each line is hsync for HS clocks, then back porch for HBP clocks, then active for HACT clocks, then front porch for HFP clocks. It then restarts at its first clock.
- R3: The vertical sequence uses the same order counted in lines (VS, VBP, VACT, VFP). The row advances only on the last clock of a line.
- R4: de is high only when the column is in the horizontal active region and the row is in the vertical active region. In that case pos_x and pos_y are the offsets from the first active pixel and the first active line. Outside it both are 0.
- R5: Writes to timing words 0 to 4 have no effect on any output until a commit has been applied.
- R6: Writing the update word (address 5) with bit 0 set requests a commit. The shadow set is copied to the active set on the last clock of the current frame, so the new timing starts at the next frame. The request then clears, and later shadow writes need a new request.
- R7: With delay D, vsync rises D clocks after the start of line 0 and falls D clocks after the start of line VS.
- R8: A delay equal to or larger than the active line total is treated as line total minus one.
- R9: A timing field of 0 behaves as a field of 1 clock or 1 line.
- R10: Register map. Address 0 holds horizontal back porch in bits 31:16 and sync width in bits 15:0. Address 1 holds horizontal front porch in 31:16 and active width in 15:0. Addresses 2 and 3 use the same layout for the vertical fields. Address 4 holds the vsync delay in bits 29:20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync after delay, active high |
| de | output | 1 | Data enable, high on visible pixels |
| pos_x | output | FLD_W | Column inside the active area |
| pos_y | output | FLD_W | Row inside the active area |

## Verification
The hardest situation to reach is the commit boundary. The bench must show that staged words stay invisible for whole frames, and that they all take effect together on the exact first clock of the next frame. The stimulus stages new horizontal words and runs more than a frame without committing. It then commits in the middle of a frame, and later stages more words after a copy has already happened. A reference model checks every clock, so a copy that comes one pixel early, one frame late, or partly applied shows up as a mismatch. The delay and zero-field cases are reached by committing control words with a mid-range delay, an over-long delay and all-zero fields.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
   parameter int unsigned FLD_W = 16;
   parameter int unsigned DLY_W = 10;
   localparam int unsigned CNT_W = FLD_W + 2;

   typedef struct packed {
      logic [FLD_W-1:0] sync;
      logic [FLD_W-1:0] back;
      logic [FLD_W-1:0] act;
      logic [FLD_W-1:0] front;
   } axis_t;

   typedef struct packed {
      axis_t            h;
      axis_t            v;
      logic [DLY_W-1:0] vdly;
   } timing_t;

   typedef enum logic [2:0] {
      ADR_H_A  = 3'd0,
      ADR_H_B  = 3'd1,
      ADR_V_A  = 3'd2,
      ADR_V_B  = 3'd3,
      ADR_CTRL = 3'd4,
      ADR_UPD  = 3'd5
   } reg_addr_e;

   // zero-length fields are stretched to one unit
   function automatic logic [FLD_W-1:0] eff(input logic [FLD_W-1:0] f);
      return (f == '0) ? FLD_W'(1) : f;
   endfunction
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
   import vtg_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned DLY_LSB   = 20,
   parameter timing_t     RESET_SET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              frame_end,
   output timing_t           active,
   output logic              pending
);
   localparam int unsigned HI_LSB = DATA_W / 2;

   timing_t shadow;
   logic    commit_wr;
   logic    apply;

   assign commit_wr = wr_en && (wr_addr == ADDR_W'(ADR_UPD)) && wr_data[0];
   assign apply     = frame_end && pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= RESET_SET;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_W'(ADR_H_A): begin
               shadow.h.back <= wr_data[HI_LSB +: FLD_W];
               shadow.h.sync <= wr_data[0 +: FLD_W];
            end
            ADDR_W'(ADR_H_B): begin
               shadow.h.front <= wr_data[HI_LSB +: FLD_W];
               shadow.h.act   <= wr_data[0 +: FLD_W];
            end
            ADDR_W'(ADR_V_A): begin
               shadow.v.back <= wr_data[HI_LSB +: FLD_W];
               shadow.v.sync <= wr_data[0 +: FLD_W];
            end
            ADDR_W'(ADR_V_B): begin
               shadow.v.front <= wr_data[HI_LSB +: FLD_W];
               shadow.v.act   <= wr_data[0 +: FLD_W];
            end
            ADDR_W'(ADR_CTRL): shadow.vdly <= wr_data[DLY_LSB +: DLY_W];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= RESET_SET;
         pending <= 1'b0;
      end else begin
         if (apply) active <= shadow;
         if (commit_wr)      pending <= 1'b1;
         else if (frame_end) pending <= 1'b0;
      end
   end
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
   import vtg_pkg::*;
#(
   parameter int unsigned CW = CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  axis_t            cfg,
   output logic [CW-1:0]    cnt,
   output logic [CW-1:0]    total,
   output logic             last,
   output logic             in_sync,
   output logic             in_act,
   output logic [FLD_W-1:0] idx
);
   logic [CW-1:0] len_s, len_b, len_a, len_f;
   logic [CW-1:0] act_lo, act_hi, off;

   assign len_s  = CW'(eff(cfg.sync));
   assign len_b  = CW'(eff(cfg.back));
   assign len_a  = CW'(eff(cfg.act));
   assign len_f  = CW'(eff(cfg.front));
   assign act_lo = len_s + len_b;
   assign act_hi = act_lo + len_a;
   assign total  = act_hi + len_f;
   assign last   = (cnt == total - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (step) cnt <= last ? '0 : cnt + CW'(1);
   end

   assign in_sync = (cnt < len_s);
   assign in_act  = (cnt >= act_lo) && (cnt < act_hi);
   assign off     = cnt - act_lo;
   assign idx     = in_act ? off[FLD_W-1:0] : '0;
endmodule

// File: rtl/vtg_vshift.sv
module vtg_vshift
   import vtg_pkg::*;
#(
   parameter int unsigned CW = CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_end,
   input  logic             v_in_sync,
   input  logic [CW-1:0]    h_cnt,
   input  logic [CW-1:0]    h_total,
   input  logic [DLY_W-1:0] dly,
   output logic             vs
);
   logic          prev_sync;
   logic [CW-1:0] d_ext, d_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prev_sync <= 1'b0;
      else if (line_end) prev_sync <= v_in_sync;
   end

   assign d_ext = CW'(dly);
   assign d_eff = (d_ext >= h_total) ? h_total - CW'(1) : d_ext;
   assign vs    = (v_in_sync && (h_cnt >= d_eff)) ||
                  (prev_sync && !v_in_sync && (h_cnt < d_eff));
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
   import vtg_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned DLY_LSB   = 20,
   parameter bit          OUT_REG   = 1'b0,
   parameter int unsigned DEF_HSYNC = 44,
   parameter int unsigned DEF_HBP   = 148,
   parameter int unsigned DEF_HACT  = 1920,
   parameter int unsigned DEF_HFP   = 88,
   parameter int unsigned DEF_VSYNC = 5,
   parameter int unsigned DEF_VBP   = 36,
   parameter int unsigned DEF_VACT  = 1080,
   parameter int unsigned DEF_VFP   = 4,
   parameter int unsigned DEF_VDLY  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic [FLD_W-1:0]  pos_x,
   output logic [FLD_W-1:0]  pos_y
);
   localparam int unsigned CW = CNT_W;
   localparam timing_t RESET_SET = '{
      h: '{sync: FLD_W'(DEF_HSYNC), back: FLD_W'(DEF_HBP),
           act: FLD_W'(DEF_HACT), front: FLD_W'(DEF_HFP)},
      v: '{sync: FLD_W'(DEF_VSYNC), back: FLD_W'(DEF_VBP),
           act: FLD_W'(DEF_VACT), front: FLD_W'(DEF_VFP)},
      vdly: DLY_W'(DEF_VDLY)};

   if (2 * FLD_W > DATA_W) begin : g_chk_fld
      $error("two timing fields must fit in one data word");
   end
   if (DLY_LSB + DLY_W > DATA_W) begin : g_chk_dly
      $error("delay field exceeds data word");
   end
   if (ADDR_W < 3) begin : g_chk_adr
      $error("address too narrow for register map");
   end
   if (CW <= DLY_W) begin : g_chk_cw
      $error("counter narrower than delay field");
   end

   timing_t          active;
   logic             pending;
   logic             frame_end;
   logic [CW-1:0]    h_cnt, h_total, v_cnt, v_total;
   logic             h_last, v_last;
   logic             h_in_sync, v_in_sync, h_in_act, v_in_act;
   logic [FLD_W-1:0] h_idx, v_idx;
   logic             hs_raw, vs_raw, de_raw;
   logic [FLD_W-1:0] x_raw, y_raw;

   assign frame_end = h_last && v_last;

   vtg_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DLY_LSB(DLY_LSB), .RESET_SET(RESET_SET)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_end(frame_end), .active(active), .pending(pending)
   );

   vtg_axis #(.CW(CW)) u_hax (
      .clk(clk), .rst_n(rst_n), .step(1'b1), .cfg(active.h),
      .cnt(h_cnt), .total(h_total), .last(h_last),
      .in_sync(h_in_sync), .in_act(h_in_act), .idx(h_idx)
   );

   vtg_axis #(.CW(CW)) u_vax (
      .clk(clk), .rst_n(rst_n), .step(h_last), .cfg(active.v),
      .cnt(v_cnt), .total(v_total), .last(v_last),
      .in_sync(v_in_sync), .in_act(v_in_act), .idx(v_idx)
   );

   vtg_vshift #(.CW(CW)) u_vs (
      .clk(clk), .rst_n(rst_n), .line_end(h_last), .v_in_sync(v_in_sync),
      .h_cnt(h_cnt), .h_total(h_total), .dly(active.vdly), .vs(vs_raw)
   );

   assign hs_raw = h_in_sync;
   assign de_raw = h_in_act && v_in_act;
   assign x_raw  = de_raw ? h_idx : '0;
   assign y_raw  = de_raw ? v_idx : '0;

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hsync <= 1'b0;
            vsync <= 1'b0;
            de    <= 1'b0;
            pos_x <= '0;
            pos_y <= '0;
         end else begin
            hsync <= hs_raw;
            vsync <= vs_raw;
            de    <= de_raw;
            pos_x <= x_raw;
            pos_y <= y_raw;
         end
      end
   end else begin : g_out_comb
      assign hsync = hs_raw;
      assign vsync = vs_raw;
      assign de    = de_raw;
      assign pos_x = x_raw;
      assign pos_y = y_raw;
   end
endmodule

// File: rtl/vid_timing_gen_chk.sv
module vid_timing_gen_chk
   import vtg_pkg::*;
#(
   parameter int unsigned CW = CNT_W,
   parameter int unsigned TW = $bits(timing_t)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CW-1:0]    h_cnt,
   input logic [CW-1:0]    v_cnt,
   input logic [CW-1:0]    h_total,
   input logic [CW-1:0]    v_total,
   input logic             h_last,
   input logic             frame_end,
   input logic             pending,
   input logic [TW-1:0]    act_bits,
   input logic [DLY_W-1:0] vdly,
   input logic             v_in_sync,
   input logic             hs_raw,
   input logic             vs_raw,
   input logic             de_raw,
   input logic [FLD_W-1:0] x_raw,
   input logic [FLD_W-1:0] y_raw
);
   // R1: reset parks both counters at the sync start
   assert_reset_start_R1: assert property (@(posedge clk)
      !rst_n |=> (h_cnt == '0 && v_cnt == '0));

   // R2: line wraps back to its first clock
   assert_line_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      h_last |=> (h_cnt == '0));

   assert_hcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      h_cnt < h_total);

   // R3: row moves only at line end and stays within the frame
   assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !h_last |=> $stable(v_cnt));

   assert_vcnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      v_cnt < v_total);

   // R4: position is zero off the visible area
   assert_pos_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !de_raw |-> (x_raw == '0 && y_raw == '0));

   // R5: active set changes only at a frame boundary
   assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(act_bits));

   // R6: a request is consumed only at a frame boundary
   assert_commit_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pending) |-> $past(frame_end));

   // R7: without delay, vsync follows the vertical sync lines exactly
   assert_vsync_nodelay_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vdly == '0) |-> (vs_raw == v_in_sync));

   // R9: every line begins with at least one sync clock
   assert_sync_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (h_cnt == '0) |-> hs_raw);
endmodule

bind vid_timing_gen vid_timing_gen_chk #(.CW(vtg_pkg::CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
   .h_total(h_total), .v_total(v_total), .h_last(h_last),
   .frame_end(frame_end), .pending(pending), .act_bits(active),
   .vdly(active.vdly), .v_in_sync(v_in_sync), .hs_raw(hs_raw),
   .vs_raw(vs_raw), .de_raw(de_raw), .x_raw(x_raw), .y_raw(y_raw)
);

// File: tb/vid_timing_gen_bench.sv
module vid_timing_gen_bench;
   localparam int HS = 2, HBP = 3, HACT = 8, HFP = 2;
   localparam int VS = 1, VBP = 2, VACT = 4, VFP = 1, VD = 0;

   logic        clk = 1'b0;
   logic        rst_n, wr_en;
   logic [2:0]  wr_addr;
   logic [31:0] wr_data;
   logic        hsync, vsync, de;
   logic [15:0] pos_x, pos_y;

   always #10 clk = ~clk;

   vid_timing_gen #(
      .DEF_HSYNC(HS), .DEF_HBP(HBP), .DEF_HACT(HACT), .DEF_HFP(HFP),
      .DEF_VSYNC(VS), .DEF_VBP(VBP), .DEF_VACT(VACT), .DEF_VFP(VFP),
      .DEF_VDLY(VD)
   ) u_vid_timing_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
      .pos_x(pos_x), .pos_y(pos_y)
   );

   // model state: 0 hs,1 hbp,2 hact,3 hfp,4 vs,5 vbp,6 vact,7 vfp,8 delay
   int    sh[9];
   int    ac[9];
   int    hc, vc;
   bit    pend;
   int    n_cmp = 0, n_bad = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   function automatic int e(int f);
      return (f == 0) ? 1 : f;
   endfunction

   always @(posedge clk) begin : model
      int htot, vtot;
      bit lw, fe;
      if (!rst_n) begin
         ac = '{HS, HBP, HACT, HFP, VS, VBP, VACT, VFP, VD};
         sh = ac;
         pend = 1'b0;
         hc = 0;
         vc = 0;
      end else begin
         htot = e(ac[0]) + e(ac[1]) + e(ac[2]) + e(ac[3]);
         vtot = e(ac[4]) + e(ac[5]) + e(ac[6]) + e(ac[7]);
         lw = (hc == htot - 1);
         fe = lw && (vc == vtot - 1);
         if (lw) begin
            hc = 0;
            vc = (vc == vtot - 1) ? 0 : vc + 1;
         end else begin
            hc = hc + 1;
         end
         if (fe && pend) ac = sh;
         if (fe) pend = 1'b0;
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin sh[1] = int'(wr_data[31:16]); sh[0] = int'(wr_data[15:0]); end
               3'd1: begin sh[3] = int'(wr_data[31:16]); sh[2] = int'(wr_data[15:0]); end
               3'd2: begin sh[5] = int'(wr_data[31:16]); sh[4] = int'(wr_data[15:0]); end
               3'd3: begin sh[7] = int'(wr_data[31:16]); sh[6] = int'(wr_data[15:0]); end
               3'd4: sh[8] = int'(wr_data[29:20]);
               3'd5: if (wr_data[0]) pend = 1'b1;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string sig, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", cur_req, sig, act, exp);
      end
   endtask

   task automatic tick();
      int hs, hb, ha, vs, vb, va, htot, d;
      bit ehs, evs, hact, vact, ede;
      @(posedge clk);
      @(negedge clk);
      hs = e(ac[0]); hb = e(ac[1]); ha = e(ac[2]);
      vs = e(ac[4]); vb = e(ac[5]); va = e(ac[6]);
      htot = hs + hb + ha + e(ac[3]);
      d = (ac[8] >= htot) ? htot - 1 : ac[8];
      ehs  = (hc < hs);
      hact = (hc >= hs + hb) && (hc < hs + hb + ha);
      vact = (vc >= vs + vb) && (vc < vs + vb + va);
      ede  = hact && vact;
      evs  = ((vc < vs) && (hc >= d)) || ((vc == vs) && (hc < d));
      chk("hsync", int'(hsync), int'(ehs));
      chk("vsync", int'(vsync), int'(evs));
      chk("de", int'(de), int'(ede));
      chk("pos_x", int'(pos_x), ede ? hc - (hs + hb) : 0);
      chk("pos_y", int'(pos_y), ede ? vc - (vs + vb) : 0);
   endtask

   task automatic run(input int n);
      repeat (n) tick();
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      wr_en   = 1'b1;
      wr_addr = a[2:0];
      wr_data = d;
      tick();
      wr_en   = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      cur_req = "R1";
      run(3);
      chk("R1 hsync in reset", int'(hsync), 1);
      chk("R1 vsync in reset", int'(vsync), 1);
      chk("R1 de in reset", int'(de), 0);
      chk("R1 pos_x in reset", int'(pos_x), 0);
      rst_n = 1'b1;
      cur_req = "R2"; run(130);
      cur_req = "R3"; run(130);
      cur_req = "R4"; run(60);
      // staged horizontal words, no commit
      cur_req = "R10";
      wr(0, {16'd1, 16'd3});
      wr(1, {16'd4, 16'd6});
      cur_req = "R5"; run(200);
      // commit mid-frame
      cur_req = "R6";
      wr(5, 32'd1);
      run(400);
      // staged vertical change without a new request
      cur_req = "R5";
      wr(3, {16'd2, 16'd3});
      run(250);
      cur_req = "R6";
      wr(5, 32'd1);
      run(300);
      // vsync delay with a two-line sync
      cur_req = "R7";
      wr(2, {16'd1, 16'd2});
      wr(4, 32'd5 << 20);
      wr(5, 32'd1);
      run(400);
      // delay past the line total
      cur_req = "R8";
      wr(4, 32'd900 << 20);
      wr(5, 32'd1);
      run(350);
      // all-zero fields
      cur_req = "R9";
      wr(0, 32'd0);
      wr(1, {16'd0, 16'd3});
      wr(2, 32'd0);
      wr(3, {16'd0, 16'd2});
      wr(4, 32'd0);
      wr(5, 32'd1);
      run(300);
      finish_run();
   end
endmodule